// File: doc/BRIEF.md
# Interrupt Pin Delivery Engine

This block sits behind the pin inputs of an I/O interrupt controller. It keeps one pending bit per pin, and it turns pending pins into memory-write messages that carry an address and a data word. Each pin has a configuration entry, supplied from outside, that gives its vector, delivery mode, destination, destination mode, trigger kind and mask. Edge-configured pins latch a rising input as a request. Level-configured pins follow the input level. The block also records a per-pin "in service" flag for level pins. That flag blocks repeat delivery until an end-of-interrupt carrying the pin's vector arrives.

Work is event driven. The following events start a service pass: an unmasked edge, a rising level input on a pin that is not in service, an end-of-interrupt that releases a pending unmasked pin, or a re-scan strobe raised after the table changes. During a pass the block delivers every eligible pin, lowest pin number first, one message per accepted transfer on a valid/ready port. Input line 0 is folded onto pin 2.

Top module: `irq_delivery_engine`

## Requirements
- R1: After reset, `msgValid` is 0 and every `inService` bit is 0.
- R2: A rise on input line 0 is handled as a request on pin 2. Pin 0 never requests, whatever its entry says.
- R3: An edge pin (entry bit 12 = 0) that sees a rising input while unmasked (entry bit 13 = 0) produces exactly one message, and its pending bit then clears. A rise while masked is dropped, so later unmasking plus a re-scan delivers nothing.
- R4: A level pin (entry bit 12 = 1) whose input is high and whose in-service bit is clear produces one message and sets its `inService` bit. It produces no further message while that bit stays set. A low input removes its request.
- R5: An end-of-interrupt with vector V clears `inService` for every level pin whose vector (entry bits 7:0) equals V. If such a pin is unmasked and its input is still high, it is delivered again. An end-of-interrupt with any other vector changes nothing.
- R6: When several pins are eligible, messages leave in ascending pin order.
- R7: A masked pin is never delivered while pending. After it is unmasked, a re-scan strobe delivers it.
- R8: The message address is 0xFEE00000 OR'd with the 16-bit destination (entry bits 29:14) placed at address bits 27:12, and the destination mode (entry bit 11) placed at address bit 2.
- R9: The message data holds the vector in bits 7:0, the delivery mode (entry bits 10:8) in bits 10:8, and the trigger kind in bit 15. All other data bits are zero.
- R10: While `msgValid` is high and `msgReady` is low, `msgValid`, `msgAddr` and `msgData` hold steady. At most one message is handed over per cycle.
- R11: A pin configured as edge has its `inService` bit cleared on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_PINS | Raw interrupt input lines |
| cfgFlat | input | NUM_PINS*30 | Per-pin configuration entries, pin p at bits [30p+29:30p] |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | 8 | Vector carried by the end-of-interrupt |
| rescan | input | 1 | Re-scan request after a table change |
| msgReady | input | 1 | Sink accepts the message |
| msgValid | output | 1 | Message available |
| msgAddr | output | 32 | Message address |
| msgData | output | 32 | Message data |
| inService | output | NUM_PINS | Per-pin in-service flags |

## Verification
The bench builds the block with NUM_PINS = 8. At that size every pin can be given a distinct vector and destination, so each message identifies the pin it came from. Scoreboard ordering then shows the ascending scan order directly. The small pin count also places the input-0 fold and several masked and level pins side by side, so suppression, end-of-interrupt release and backpressure can each be observed on a pin whose neighbours keep their own distinct settings.

// File: rtl/irqdel_pkg.sv
package irqdel_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic [15:0] dest;
    logic        masked;
    logic        trigLevel;
    logic        destMode;
    logic [2:0]  delivMode;
    logic [7:0]  vector;
  } pinEntry_t;

  localparam int ENTRY_W = $bits(pinEntry_t);

  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] idx;
  } svcStrobe_t;

  localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;
endpackage

// File: rtl/irqdel_control.sv
module irqdel_control
  import irqdel_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] eligible,
  input  logic [NUM_PINS-1:0] armReq,
  input  logic                rescan,
  input  logic                msgValid,
  input  logic                msgReady,
  output svcStrobe_t          ctl
);
  logic armed;
  logic anyElig;
  logic slotFree;
  logic [IDX_W-1:0] pick;

  assign anyElig  = |eligible;
  assign slotFree = !msgValid || msgReady;

  always_comb begin
    pick = '0;
    for (int p = NUM_PINS - 1; p >= 0; p--) begin
      if (eligible[p]) pick = IDX_W'(p);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= (|armReq) || rescan || (armed && anyElig);
  end

  assign ctl.load = armed && anyElig && slotFree;
  assign ctl.idx  = pick;

  // R10: no load while an unaccepted message occupies the output
  p_no_overwrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msgValid && !msgReady) |-> !ctl.load);
endmodule

// File: rtl/irqdel_datapath.sv
module irqdel_datapath
  import irqdel_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         pinIn,
  input  logic [NUM_PINS*ENTRY_W-1:0] cfgFlat,
  input  logic                        eoiValid,
  input  logic [7:0]                  eoiVector,
  input  logic                        msgReady,
  input  svcStrobe_t                  ctl,
  output logic [NUM_PINS-1:0]         eligible,
  output logic [NUM_PINS-1:0]         armReq,
  output logic [NUM_PINS-1:0]         inService,
  output logic                        msgValid,
  output logic [31:0]                 msgAddr,
  output logic [31:0]                 msgData
);
  localparam int FOLD_SRC = 0;
  localparam int FOLD_DST = 2;

  pinEntry_t cfg [NUM_PINS];
  logic [NUM_PINS-1:0] pinMapped, pinSync, pinRise;
  logic [NUM_PINS-1:0] pendEdge, pending, loadHit, lowerMask, eoiHit;
  logic [NUM_PINS-1:0] trigLvl, maskBit, edgeSet;
  pinEntry_t selEntry;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign cfg[p]     = pinEntry_t'(cfgFlat[p*ENTRY_W +: ENTRY_W]);
    assign trigLvl[p] = cfg[p].trigLevel;
    assign maskBit[p] = cfg[p].masked;
    if (p == FOLD_SRC) begin : g_src
      assign pinMapped[p] = 1'b0;
    end else if (p == FOLD_DST) begin : g_dst
      assign pinMapped[p] = pinIn[p] | pinIn[FOLD_SRC];
    end else begin : g_direct
      assign pinMapped[p] = pinIn[p];
    end
  end

  assign pinRise = pinMapped & ~pinSync;
  assign edgeSet = pinRise & ~trigLvl & ~maskBit;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      loadHit[p]   = ctl.load && (ctl.idx == IDX_W'(p));
      lowerMask[p] = IDX_W'(p) < ctl.idx;
      pending[p]   = trigLvl[p] ? pinSync[p] : pendEdge[p];
      eligible[p]  = pending[p] && !maskBit[p] && !(trigLvl[p] && inService[p]);
      eoiHit[p]    = eoiValid && inService[p] && (cfg[p].vector == eoiVector);
      armReq[p]    = edgeSet[p]
                   || (pinRise[p] && trigLvl[p] && !inService[p])
                   || (eoiHit[p] && trigLvl[p] && !maskBit[p] && pending[p]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pinSync   <= '0;
      pendEdge  <= '0;
      inService <= '0;
    end else begin
      pinSync <= pinMapped;
      for (int p = 0; p < NUM_PINS; p++) begin
        pendEdge[p] <= edgeSet[p] || (pendEdge[p] && !(loadHit[p] && !trigLvl[p]));
        if (!trigLvl[p])     inService[p] <= 1'b0;
        else if (loadHit[p]) inService[p] <= 1'b1;
        else if (eoiHit[p])  inService[p] <= 1'b0;
      end
    end
  end

  always_comb begin
    selEntry = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (ctl.idx == IDX_W'(p)) selEntry = cfg[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msgValid <= 1'b0;
      msgAddr  <= '0;
      msgData  <= '0;
    end else if (ctl.load) begin
      msgValid <= 1'b1;
      msgAddr  <= MSG_BASE | {4'b0, selEntry.dest, 12'b0} | {29'b0, selEntry.destMode, 2'b0};
      msgData  <= {16'b0, selEntry.trigLevel, 4'b0, selEntry.delivMode, selEntry.vector};
    end else if (msgReady) begin
      msgValid <= 1'b0;
    end
  end

  // R10: backpressure holds the message
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData)));

  // R6: a load picks an eligible pin with no lower eligible pin
  p_lowest_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |-> ((|(eligible & loadHit)) && !(|(eligible & lowerMask))));

  // R10: at most one pin loaded per cycle
  p_single_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(loadHit));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    // R11: edge-configured pins lose the in-service flag
    p_edge_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !trigLvl[p] |=> !inService[p]);
    // R4: delivering a level pin marks it in service
    p_level_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (loadHit[p] && trigLvl[p]) |=> inService[p]);
    // R5: a matching end-of-interrupt releases the pin
    p_eoi_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eoiHit[p] && !loadHit[p]) |=> !inService[p]);
  end
endmodule

// File: rtl/irq_delivery_engine.sv
module irq_delivery_engine
  import irqdel_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         pinIn,
  input  logic [NUM_PINS*ENTRY_W-1:0] cfgFlat,
  input  logic                        eoiValid,
  input  logic [7:0]                  eoiVector,
  input  logic                        rescan,
  input  logic                        msgReady,
  output logic                        msgValid,
  output logic [31:0]                 msgAddr,
  output logic [31:0]                 msgData,
  output logic [NUM_PINS-1:0]         inService
);
  svcStrobe_t ctl;
  logic [NUM_PINS-1:0] eligible, armReq;

  irqdel_control #(.NUM_PINS(NUM_PINS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .eligible(eligible), .armReq(armReq),
    .rescan(rescan), .msgValid(msgValid), .msgReady(msgReady), .ctl(ctl)
  );

  irqdel_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .cfgFlat(cfgFlat),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .msgReady(msgReady),
    .ctl(ctl), .eligible(eligible), .armReq(armReq), .inService(inService),
    .msgValid(msgValid), .msgAddr(msgAddr), .msgData(msgData)
  );

  // R1: nothing in service and nothing offered right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!msgValid && inService == '0));
endmodule

// File: tb/tb_irq_delivery_engine.sv
module tb_irq_delivery_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int EW = 30;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] pinIn = '0;
  logic [NP*EW-1:0] cfgFlat;
  logic eoiValid = 0, rescan = 0, msgReady = 1;
  logic [7:0] eoiVector = '0;
  logic msgValid;
  logic [31:0] msgAddr, msgData;
  logic [NP-1:0] inService;
  logic [EW-1:0] cfgArr [NP];

  int checks = 0, errors = 0, accepted = 0;
  logic [63:0] expQ [$];
  logic holdPend = 0;
  logic [63:0] holdVal;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int p = 0; p < NP; p++) cfgFlat[p*EW +: EW] = cfgArr[p];

  irq_delivery_engine #(.NUM_PINS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .cfgFlat(cfgFlat),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .rescan(rescan),
    .msgReady(msgReady), .msgValid(msgValid), .msgAddr(msgAddr),
    .msgData(msgData), .inService(inService)
  );

  function automatic logic [EW-1:0] mk(input logic [7:0] vec, input logic [2:0] dm,
      input logic dmode, input logic lvl, input logic msk, input logic [15:0] dst);
    return {dst, msk, lvl, dmode, dm, vec};
  endfunction

  // R8, R9: expected message from an entry
  function automatic logic [63:0] expMsg(input logic [EW-1:0] e);
    logic [31:0] a, d;
    a = 32'hFEE0_0000 | (32'(e[29:14]) << 12) | (32'(e[11]) << 2);
    d = 32'(e[7:0]) | (32'(e[10:8]) << 8) | (32'(e[12]) << 15);
    return {a, d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  // monitor: scoreboard compare plus hold check
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (holdPend)
        check(msgValid && {msgAddr, msgData} == holdVal, "R10 hold", {msgAddr, msgData}, holdVal);
      if (msgValid && msgReady) begin
        accepted++;
        if (expQ.size() == 0) check(0, "R3/R4 unexpected message", {msgAddr, msgData}, 64'h0);
        else begin
          logic [63:0] e;
          e = expQ.pop_front();
          check({msgAddr, msgData} == e, "R8/R9 message", {msgAddr, msgData}, e);
        end
      end
      holdPend = msgValid && !msgReady;
      holdVal  = {msgAddr, msgData};
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    for (int p = 0; p < NP; p++)
      cfgArr[p] = mk(8'h10 + 8'(p) * 8'h11, 3'(p), p[0], 1'b0, 1'b0, 16'h1200 + 16'(p));
    tick(3);
    // R1 reset state
    check(!msgValid, "R1 valid", 64'(msgValid), 64'h0);
    check(inService == '0, "R1 inService", 64'(inService), 64'h0);
    rst_n = 1;
    tick(2);

    // R3: edge pin 3 unmasked, one message
    base = accepted;
    expQ.push_back(expMsg(cfgArr[3]));
    @(negedge clk) pinIn[3] = 1; @(negedge clk) pinIn[3] = 0;
    tick(8);
    check(accepted == base + 1, "R3 one message", 64'(accepted - base), 64'd1);
    @(negedge clk) rescan = 1; @(negedge clk) rescan = 0;
    tick(6);
    check(accepted == base + 1, "R3 pending cleared", 64'(accepted - base), 64'd1);

    // R2: line 0 goes to pin 2
    base = accepted;
    expQ.push_back(expMsg(cfgArr[2]));
    @(negedge clk) pinIn[0] = 1; @(negedge clk) pinIn[0] = 0;
    tick(8);
    check(accepted == base + 1, "R2 fold count", 64'(accepted - base), 64'd1);

    // R3: masked edge dropped
    base = accepted;
    cfgArr[4] = mk(8'h44, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0044);
    @(negedge clk) pinIn[4] = 1; @(negedge clk) pinIn[4] = 0;
    tick(4);
    cfgArr[4] = mk(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0044);
    @(negedge clk) rescan = 1; @(negedge clk) rescan = 0;
    tick(6);
    check(accepted == base, "R3 masked edge", 64'(accepted - base), 64'd0);

    // R4: level pin 5
    base = accepted;
    cfgArr[5] = mk(8'h55, 3'd1, 1'b1, 1'b1, 1'b0, 16'hABCD);
    expQ.push_back(expMsg(cfgArr[5]));
    @(negedge clk) pinIn[5] = 1;
    tick(8);
    check(inService[5], "R4 in service", 64'(inService), 64'h20);
    tick(8);
    check(accepted == base + 1, "R4 no repeat", 64'(accepted - base), 64'd1);
    // R5: non-matching EOI ignored
    @(negedge clk) begin eoiValid = 1; eoiVector = 8'h99; end
    @(negedge clk) eoiValid = 0;
    tick(4);
    check(inService[5] && accepted == base + 1, "R5 other vector", 64'(inService), 64'h20);
    // R5: matching EOI with input high redelivers
    expQ.push_back(expMsg(cfgArr[5]));
    @(negedge clk) begin eoiValid = 1; eoiVector = 8'h55; end
    @(negedge clk) eoiValid = 0;
    tick(8);
    check(accepted == base + 2 && inService[5], "R5 redeliver", 64'(accepted - base), 64'd2);
    // R4: low input removes request
    @(negedge clk) pinIn[5] = 0;
    tick(2);
    @(negedge clk) begin eoiValid = 1; eoiVector = 8'h55; end
    @(negedge clk) eoiValid = 0;
    tick(8);
    check(!inService[5] && accepted == base + 2, "R4 low clears", 64'(inService), 64'h0);
    // R11: switching to edge clears in-service
    expQ.push_back(expMsg(cfgArr[5]));
    @(negedge clk) pinIn[5] = 1;
    tick(8);
    check(inService[5], "R11 set first", 64'(inService), 64'h20);
    cfgArr[5] = mk(8'h55, 3'd1, 1'b1, 1'b0, 1'b0, 16'hABCD);
    tick(3);
    check(!inService[5], "R11 edge clears", 64'(inService), 64'h0);
    @(negedge clk) pinIn[5] = 0;
    tick(4);

    // R6 + R10: two pins at once under backpressure
    base = accepted;
    msgReady = 0;
    expQ.push_back(expMsg(cfgArr[1]));
    expQ.push_back(expMsg(cfgArr[6]));
    @(negedge clk) begin pinIn[1] = 1; pinIn[6] = 1; end
    @(negedge clk) begin pinIn[1] = 0; pinIn[6] = 0; end
    tick(5);
    check(msgValid && msgData[7:0] == cfgArr[1][7:0], "R6 lowest first", 64'(msgData), 64'(cfgArr[1][7:0]));
    @(negedge clk) msgReady = 1;
    tick(8);
    check(accepted == base + 2, "R6 both delivered", 64'(accepted - base), 64'd2);

    // R7: masked level pin then unmask + rescan
    base = accepted;
    cfgArr[7] = mk(8'h77, 3'd5, 1'b0, 1'b1, 1'b1, 16'h0707);
    @(negedge clk) pinIn[7] = 1;
    tick(8);
    check(accepted == base && !inService[7], "R7 masked skipped", 64'(accepted - base), 64'd0);
    cfgArr[7] = mk(8'h77, 3'd5, 1'b0, 1'b1, 1'b0, 16'h0707);
    expQ.push_back(expMsg(cfgArr[7]));
    @(negedge clk) rescan = 1; @(negedge clk) rescan = 0;
    tick(8);
    check(accepted == base + 1 && inService[7], "R7 after rescan", 64'(accepted - base), 64'd1);

    tick(4);
    check(expQ.size() == 0, "R3/R4 all expected seen", 64'(expQ.size()), 64'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule